// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block decides where each memory access goes when system-management memory has to be hidden from ordinary masters. It holds two small control bytes. The first is the legacy byte, with open, close, lock and global-enable bits. The second is the extended byte, with high-alias enable, TSEG enable and a TSEG size code. It also holds a 16-bit size-query register.

Each access presents a 32-bit physical address and an SMM-mode flag. The block then names one of three routes: RAM, the PCI/VGA space, or a blackhole in which reads return all ones and writes are dropped. Along with the route it gives the RAM address to use. That address differs from the input only for the high alias at 0xFEDA0000, which is folded onto the legacy window at 0xA0000.

The TSEG region is cut from the top of low memory, which is set by the parameter `LOW_TOP`. The lock bit is sticky until reset. Once set, it shrinks what software may change in both control bytes.

Top module: `smm_window_ctl`

## Requirements
- R1: After reset, `legacy_q` and `ext_q` read 0x00. `query_q` reads 0xFFFF (the query code) when the extended size `EXT_MB` is nonzero, and 0x0000 otherwise.
- R2: A write with `cfg_we`=1 targets a register chosen by `cfg_sel`: 0 selects the legacy byte, 1 the extended byte, 2 the query register. The new value reads back on the cycle after the write. The legacy bits are open=bit0, close=bit1, lock=bit2 and global enable=bit3. The extended bits are high enable=bit0, TSEG enable=bit1 and size code=bits[3:2]. Bits [7:4] of both bytes always read 0.
- R3: A legacy write whose result has lock=1 also clears open in the same update. Once lock is 1, it stays 1 until reset. While locked, only the close bit of the legacy byte can be written, and the extended byte ignores writes.
- R4: For a non-SMM access, the low window 0xA0000–0xBFFFF routes to RAM (route 0) when open=1 and high enable=0. Otherwise it routes to PCI (route 1).
- R5: For a non-SMM access, the high alias 0xFEDA0000–0xFEDBFFFF routes to RAM when open=1 and high enable=1, and to PCI otherwise. Whenever this alias routes to RAM, `ram_addr` is 0xA0000 plus the offset into the alias.
- R6: For an SMM access with global enable=1, the low window routes to RAM when high enable=0, and the high alias routes to RAM (remapped) when high enable=1. In every other case an SMM access to either window follows the non-SMM rules.
- R7: With TSEG enabled, size codes 0, 1 and 2 give 1, 2 and 8 MB, and code 3 gives `EXT_MB` MB. With TSEG disabled the size is 0.
- R8: The region [LOW_TOP − size, LOW_TOP) routes to the blackhole (route 2) for non-SMM accesses and to RAM for SMM accesses.
- R9: A write of the query code 0xFFFF to the query register, while `EXT_MB` is nonzero, stores `EXT_MB` instead. Any other written value is stored as written.
- R10: Any other address routes to RAM when it is below `LOW_TOP` and to PCI otherwise. In these cases `ram_addr` equals `acc_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 legacy, 1 extended, 2 query |
| cfg_wdata | input | 16 | Write data (bytes use bits [7:0]) |
| legacy_q | output | 8 | Legacy control byte |
| ext_q | output | 8 | Extended control byte |
| query_q | output | 16 | Size-query register |
| acc_addr | input | 32 | Physical address of the access |
| acc_smm | input | 1 | Access is made in SMM mode |
| route | output | 2 | 0 RAM, 1 PCI/VGA, 2 blackhole |
| ram_addr | output | 32 | RAM address after alias remapping |

## Verification
Random sequences of register writes with the lock bit held off cover every combination of open, global enable, high enable and size code. Each combination is probed with addresses drawn from the low window, the high alias, the span near `LOW_TOP`, plain low memory and high memory, in both SMM and non-SMM mode. Together these separate the window rules from the TSEG rule and from the default rule. Directed cases then probe the exact edges of the 1, 2, 8 and 16 MB regions, the query substitution, and the lock sequence: open forced low, lock sticky, close still writable, and the extended byte frozen.

// File: rtl/smm_window_ctl.sv
module smm_window_ctl #(
  parameter logic [31:0] LOW_TOP    = 32'h8000_0000,
  parameter int          EXT_MB     = 16,
  parameter logic [15:0] QUERY_CODE = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic [7:0]  legacy_q,
  output logic [7:0]  ext_q,
  output logic [15:0] query_q,
  input  logic [31:0] acc_addr,
  input  logic        acc_smm,
  output logic [1:0]  route,
  output logic [31:0] ram_addr
);
  localparam logic [31:0] LOW_BASE  = 32'h000A_0000;
  localparam logic [31:0] HIGH_BASE = 32'hFEDA_0000;
  localparam logic [31:0] WIN_SIZE  = 32'h0002_0000;
  localparam logic [15:0] EXT_SIZE  = 16'(EXT_MB);
  localparam logic [15:0] QRY_RST   = (EXT_MB != 0) ? QUERY_CODE : 16'h0000;
  localparam logic [1:0]  RT_RAM = 2'd0, RT_PCI = 2'd1, RT_HOLE = 2'd2;

  logic [3:0]  leg, ext, leg_m, ext_m, leg_nx, ext_nx;
  logic [15:0] qry, qry_nx, tseg_mb;
  logic [35:0] tseg_sz, tseg_lo;
  logic        in_low, in_high, in_tseg;

  wire open = leg[0];
  wire lock = leg[2];
  wire gen  = leg[3];
  wire hen  = ext[0];
  wire ten  = ext[1];

  assign leg_m = lock ? 4'b0010 : 4'b1111;
  assign ext_m = lock ? 4'b0000 : 4'b1111;

  always_comb begin
    leg_nx = (leg & ~leg_m) | (cfg_wdata[3:0] & leg_m);
    if (leg_nx[2]) leg_nx[0] = 1'b0;
    ext_nx = (ext & ~ext_m) | (cfg_wdata[3:0] & ext_m);
    qry_nx = (EXT_MB != 0 && cfg_wdata == QUERY_CODE) ? EXT_SIZE : cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leg <= '0;
      ext <= '0;
      qry <= QRY_RST;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    leg <= leg_nx;
        2'd1:    ext <= ext_nx;
        2'd2:    qry <= qry_nx;
        default: ;
      endcase
    end
  end

  assign legacy_q = {4'b0, leg};
  assign ext_q    = {4'b0, ext};
  assign query_q  = qry;

  always_comb begin
    case (ext[3:2])
      2'd0:    tseg_mb = 16'd1;
      2'd1:    tseg_mb = 16'd2;
      2'd2:    tseg_mb = 16'd8;
      default: tseg_mb = EXT_SIZE;
    endcase
    if (!ten) tseg_mb = '0;
  end

  assign tseg_sz = {tseg_mb, 20'b0};
  assign tseg_lo = (tseg_sz > {4'b0, LOW_TOP}) ? 36'd0 : {4'b0, LOW_TOP} - tseg_sz;

  assign in_low  = acc_addr >= LOW_BASE  && acc_addr < LOW_BASE + WIN_SIZE;
  assign in_high = acc_addr >= HIGH_BASE && acc_addr < HIGH_BASE + WIN_SIZE;
  assign in_tseg = tseg_mb != 0 && {4'b0, acc_addr} >= tseg_lo && acc_addr < LOW_TOP;

  always_comb begin
    if (in_tseg)
      route = acc_smm ? RT_RAM : RT_HOLE;
    else if (in_low)
      route = ((acc_smm && gen && !hen) || (open && !hen)) ? RT_RAM : RT_PCI;
    else if (in_high)
      route = ((acc_smm && gen && hen) || (open && hen)) ? RT_RAM : RT_PCI;
    else
      route = (acc_addr < LOW_TOP) ? RT_RAM : RT_PCI;
  end

  assign ram_addr = (in_high && !in_tseg && route == RT_RAM) ?
                    LOW_BASE + (acc_addr - HIGH_BASE) : acc_addr;

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_q[2] |=> legacy_q[2]);
  a_r3_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_q[2] |-> !legacy_q[0]);
  a_r3_ext_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_q[2] && $past(legacy_q[2])) |-> $stable(ext_q));
  a_r8_top_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_smm && ext_q[1] && acc_addr == LOW_TOP - 32'd1) |-> route == RT_HOLE);
  a_r5_alias_needs_hen: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_RAM && acc_addr >= HIGH_BASE && acc_addr < HIGH_BASE + WIN_SIZE) |-> ext_q[0]);
  a_r2_route_legal: assert property (@(posedge clk) disable iff (!rst_n)
    route != 2'd3);
endmodule

// File: tb/tb_smm_window_ctl.sv
module tb_smm_window_ctl;
  localparam int PERIOD = 10;
  localparam logic [31:0] TOP = 32'h8000_0000;
  localparam int XMB = 16;

  logic        clk = 0, rst_n = 0, cfg_we = 0, acc_smm = 0;
  logic [1:0]  cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic [31:0] acc_addr = 0;
  logic [7:0]  legacy_q, ext_q;
  logic [15:0] query_q;
  logic [1:0]  route;
  logic [31:0] ram_addr;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [3:0]  m_leg, m_ext;
  logic [15:0] m_qry;

  smm_window_ctl #(.LOW_TOP(TOP), .EXT_MB(XMB)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .legacy_q(legacy_q), .ext_q(ext_q), .query_q(query_q),
    .acc_addr(acc_addr), .acc_smm(acc_smm), .route(route), .ram_addr(ram_addr));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int tseg_bytes();
    int mb;
    if (!m_ext[1]) return 0;
    case (m_ext[3:2])
      2'd0: mb = 1; 2'd1: mb = 2; 2'd2: mb = 8; default: mb = XMB;
    endcase
    return mb << 20;
  endfunction

  function automatic logic [1:0] exp_route(logic [31:0] a, logic smm);
    logic o, g, h;
    int sz;
    o = m_leg[0]; g = m_leg[3]; h = m_ext[0];
    sz = tseg_bytes();
    if (sz != 0 && a >= TOP - 32'(sz) && a < TOP) return smm ? 2'd0 : 2'd2;
    if (a >= 32'hA0000 && a <= 32'hBFFFF) return ((smm && g && !h) || (o && !h)) ? 2'd0 : 2'd1;
    if (a >= 32'hFEDA0000 && a <= 32'hFEDBFFFF) return ((smm && g && h) || (o && h)) ? 2'd0 : 2'd1;
    return (a < TOP) ? 2'd0 : 2'd1;
  endfunction

  function automatic logic [31:0] exp_ram(logic [31:0] a, logic smm);
    if (a >= 32'hFEDA0000 && a <= 32'hFEDBFFFF && exp_route(a, smm) == 2'd0)
      return 32'hA0000 + (a - 32'hFEDA0000);
    return a;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    m_leg = 0; m_ext = 0; m_qry = 16'hFFFF;
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    logic [3:0] lm;
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    lm = m_leg[2] ? 4'b0010 : 4'b1111;
    case (sel)
      2'd0: begin
        m_leg = (m_leg & ~lm) | (d[3:0] & lm);
        if (m_leg[2]) m_leg[0] = 0;
      end
      2'd1: if (!m_leg[2]) m_ext = d[3:0];
      2'd2: m_qry = (d == 16'hFFFF) ? 16'(XMB) : d;
      default: ;
    endcase
  endtask

  task automatic probe(string req, logic [31:0] a, logic smm);
    acc_addr = a; acc_smm = smm; #1;
    chk(req, {30'b0, route}, {30'b0, exp_route(a, smm)});
    chk(req, ram_addr, exp_ram(a, smm));
  endtask

  function automatic logic [31:0] pick_addr(int k);
    case (k)
      0: return 32'hA0000 + ($urandom % 32'h20000);
      1: return 32'hFEDA0000 + ($urandom % 32'h20000);
      2: return TOP - 32'h0100_0000 + ($urandom % 32'h0100_0000);
      3: return ($urandom % 32'h9_0000);
      4: return 32'hC000_0000 + ($urandom % 32'h1000_0000);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    chk("R1 legacy", {24'b0, legacy_q}, 32'h00);
    chk("R1 ext", {24'b0, ext_q}, 32'h00);
    chk("R1 query", {16'b0, query_q}, 32'hFFFF);

    wr(2'd0, 16'h00F9);
    chk("R2 legacy upper zero", {24'b0, legacy_q}, 32'h09);
    wr(2'd1, 16'h00F6);
    chk("R2 ext upper zero", {24'b0, ext_q}, 32'h06);

    wr(2'd2, 16'h1234);
    chk("R9 plain store", {16'b0, query_q}, 32'h1234);
    wr(2'd2, 16'hFFFF);
    chk("R9 query substitution", {16'b0, query_q}, XMB);

    for (int c = 0; c < 4; c++) begin
      int sz;
      wr(2'd1, 16'((c << 2) | 2));
      sz = (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 8 : XMB;
      probe("R7 R8 tseg low edge", TOP - 32'(sz << 20), 1'b0);
      chk("R7 size code edge", {30'b0, route}, 32'd2);
      probe("R7 below tseg", TOP - 32'(sz << 20) - 1, 1'b0);
      chk("R10 below tseg ram", {30'b0, route}, 32'd0);
      probe("R8 smm in tseg", TOP - 1, 1'b1);
      chk("R8 smm tseg ram", {30'b0, route}, 32'd0);
    end
    wr(2'd1, 16'h000C);
    probe("R7 disabled", TOP - 1, 1'b0);
    chk("R7 disabled ram", {30'b0, route}, 32'd0);

    wr(2'd0, 16'h0001); wr(2'd1, 16'h0001);
    probe("R5 alias open", 32'hFEDA1234, 1'b0);
    chk("R5 remap", ram_addr, 32'hA1234);
    probe("R4 low hidden h=1", 32'hA0010, 1'b0);
    chk("R4 pci", {30'b0, route}, 32'd1);
    wr(2'd1, 16'h0000);
    probe("R4 low open", 32'hBFFFF, 1'b0);
    chk("R4 ram", {30'b0, route}, 32'd0);
    wr(2'd0, 16'h0008);
    probe("R6 smm low", 32'hA0000, 1'b1);
    chk("R6 ram", {30'b0, route}, 32'd0);
    probe("R4 closed", 32'hA0000, 1'b0);
    chk("R4 closed pci", {30'b0, route}, 32'd1);
    probe("R10 high mem", 32'hC000_0000, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if ($urandom % 2) wr(2'd0, d & 16'hFFFB);
      else wr(2'd1, d);
      chk("R2 legacy readback", {24'b0, legacy_q}, {28'b0, m_leg});
      chk("R2 ext readback", {24'b0, ext_q}, {28'b0, m_ext});
      for (int j = 0; j < 8; j++)
        probe("R4 R5 R6 R8 R10 random", pick_addr($urandom % 6), 1'($urandom));
    end

    wr(2'd1, 16'h0007);
    wr(2'd0, 16'h000F);
    chk("R3 lock clears open", {24'b0, legacy_q}, 32'h0E);
    wr(2'd1, 16'h0008);
    chk("R3 ext frozen", {24'b0, ext_q}, 32'h07);
    wr(2'd0, 16'h0001);
    chk("R3 lock sticky close only", {24'b0, legacy_q}, 32'h0C);
    probe("R3 locked alias", 32'hFEDA0000, 1'b0);
    chk("R3 alias hidden", {30'b0, route}, 32'd1);
    probe("R6 locked smm alias", 32'hFEDA0000, 1'b1);
    do_reset();
    @(negedge clk);
    chk("R1 lock cleared by reset", {24'b0, legacy_q}, 32'h00);
    chk("R1 query after reset", {16'b0, query_q}, 32'hFFFF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule